// File: doc/BRIEF.md
# Printer Port Interrupt Controller

This block sits beside a parallel printer port and turns activity on the printer's acknowledge and fault lines into a host interrupt request. Both printer lines are brought onto the system clock through a chain of synchronizer flops. Edges are detected only on the synchronized copies. When the unit is enabled, a selected edge of the acknowledge line or a falling edge of the fault line latches a pending flag. The unit raises a request while any flag is pending and the enable is set.

Software sees one byte-wide control and status register. The low five bits hold plain settings:

| Bits | Setting |
|------|---------|
| 2:0 | Request priority level |
| 3 | Enable |
| 4 | Acknowledge edge select |

The upper three bits report status:

| Bit | Status |
|-----|--------|
| 5 | Acknowledge event pending |
| 6 | Fault event pending |
| 7 | Summary of the two pending flags |

Writing a one to a pending bit clears it. Writing zero to the enable also drops the acknowledge flag. The priority level is presented on its own output next to the request.

Top module: `prn_irq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the register reads 0x00, and `irq_req` and `irq_level` are low.
- R2: A write stores bits 4..0 of the write data, and they read back unchanged. `irq_level` always equals register bits 2..0.
- R3: With enable (bit 3) set, a selected acknowledge edge sets bit 5. Bit 4 = 0 selects a rising edge and bit 4 = 1 selects a falling edge. The flag reads back after the third rising clock edge that follows the input change.
- R4: With enable set, a falling edge of `fault_in` sets bit 6. A rising edge of `fault_in` does not set it.
- R5: Each write acts on the pending bits as follows:
  - Writing 1 to bit 5 or bit 6 clears that flag.
  - Writing 0 to bit 5 or bit 6 leaves that flag unchanged.
  - Write data bit 7 is ignored.
- R6: If a flag's detected edge and a write-one-to-clear of that flag fall in the same clock cycle, the flag stays set.
- R7: A write that leaves enable at 0 clears bit 5. Bit 6 is not affected by the enable.
- R8: While enable is 0, no edge on either input sets a pending flag.
- R9: Bit 7 reads as the OR of bits 5 and 6.
- R10: `irq_req` is high exactly when bit 7 and enable are both set.
- R11: With enable set, an acknowledge edge of the non-selected direction leaves bit 5 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, sampled on the clock edge |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register contents (combinational read) |
| ack_in | input | 1 | Printer acknowledge line, asynchronous |
| fault_in | input | 1 | Printer fault line, asynchronous |
| irq_req | output | 1 | Interrupt request toward the host |
| irq_level | output | 3 | Priority level of the request |

## Verification
The assertions assume two things:
- `reg_wr` and `reg_wdata` are clean synchronous signals.
- Each printer input holds every level for at least one full clock after it changes, so every change gives exactly one detected event.

The bench drives all inputs on the falling clock edge and holds each printer level for several cycles. The coincidence case for R6 is the only place where a write is aligned on purpose with the cycle in which the synchronized edge shows. The bench never disables the unit in the same cycle as an acknowledge edge, because that is the one case in which the disable overrides the edge.

// File: rtl/prn_irq_pkg.sv
package prn_irq_pkg;

  localparam int REG_W   = 8;
  localparam int LVL_W   = 3;
  // bit positions that software decodes
  localparam int B_EN    = 3;
  localparam int B_POL   = 4;
  localparam int B_ACKP  = 5;
  localparam int B_FLTP  = 6;
  localparam int B_SUM   = 7;
  localparam int CTRL_W  = B_POL + 1;

  // edge selected by polarity: pol=0 rising, pol=1 falling
  function automatic logic ack_edge(input logic cur, input logic prev, input logic pol);
    return pol ? (prev & ~cur) : (cur & ~prev);
  endfunction

  function automatic logic fall_edge(input logic cur, input logic prev);
    return prev & ~cur;
  endfunction

  // next pending flag: event wins over clear, keep=0 forces clear
  function automatic logic pend_next(input logic evt, input logic cur,
                                     input logic clr, input logic keep);
    return keep & (evt | (cur & ~clr));
  endfunction

endpackage

// File: rtl/prn_sync_edge.sv
module prn_sync_edge #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync_q,
  output logic [W-1:0] prev_q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= din;
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chain[STAGES-1];
  end

  assign sync_q = chain[STAGES-1];

endmodule

// File: rtl/prn_irq_regs.sv
module prn_irq_regs
  import prn_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              ack_evt,
  input  logic              fault_evt,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              ack_pend_q,
  output logic              fault_pend_q
);

  logic [CTRL_W-1:0] ctrl_d;
  logic              ack_clr;
  logic              fault_clr;

  assign ctrl_d    = reg_wr ? reg_wdata[CTRL_W-1:0] : ctrl_q;
  assign ack_clr   = reg_wr & reg_wdata[B_ACKP];
  assign fault_clr = reg_wr & reg_wdata[B_FLTP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= '0;
      ack_pend_q   <= 1'b0;
      fault_pend_q <= 1'b0;
    end else begin
      ctrl_q       <= ctrl_d;
      ack_pend_q   <= pend_next(ack_evt, ack_pend_q, ack_clr, ctrl_d[B_EN]);
      fault_pend_q <= pend_next(fault_evt, fault_pend_q, fault_clr, 1'b1);
    end
  end

endmodule

// File: rtl/prn_irq_ctrl.sv
module prn_irq_ctrl
  import prn_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             ack_in,
  input  logic             fault_in,
  output logic             irq_req,
  output logic [2:0]       irq_level
);

  logic [1:0]        sync_q;
  logic [1:0]        prev_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              ack_pend_q;
  logic              fault_pend_q;
  logic              unit_en;
  logic              ack_evt;
  logic              fault_evt;
  logic              any_pend;

  prn_sync_edge #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    ({fault_in, ack_in}),
    .sync_q (sync_q),
    .prev_q (prev_q)
  );

  assign unit_en   = ctrl_q[B_EN];
  assign ack_evt   = unit_en & ack_edge(sync_q[0], prev_q[0], ctrl_q[B_POL]);
  assign fault_evt = unit_en & fall_edge(sync_q[1], prev_q[1]);

  prn_irq_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .ack_evt      (ack_evt),
    .fault_evt    (fault_evt),
    .ctrl_q       (ctrl_q),
    .ack_pend_q   (ack_pend_q),
    .fault_pend_q (fault_pend_q)
  );

  assign any_pend  = ack_pend_q | fault_pend_q;
  assign reg_rdata = {any_pend, fault_pend_q, ack_pend_q, ctrl_q};
  assign irq_req   = any_pend & unit_en;
  assign irq_level = ctrl_q[LVL_W-1:0];

endmodule

// File: rtl/prn_irq_chk.sv
module prn_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       irq_req,
  input logic [2:0] irq_level,
  input logic       ack_evt,
  input logic       fault_evt
);

  a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata[4:0] == $past(reg_wdata[4:0]));

  a_r2_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level == reg_rdata[2:0]);

  a_r3_ack_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && !(reg_wr && !reg_wdata[3])) |=> reg_rdata[5]);

  a_r4_fault_set: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> reg_rdata[6]);

  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[5] && !ack_evt) |=> !reg_rdata[5]);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !fault_evt) |=> $stable(reg_rdata[6]));

  a_r7_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[3] |-> !reg_rdata[5]);

  a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[3] |-> (!ack_evt && !fault_evt));

  a_r9_summary: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7] |-> (reg_rdata[5] || reg_rdata[6]));

  a_r10_req: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (reg_rdata[3] && reg_rdata[7]));

endmodule

bind prn_irq_ctrl prn_irq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_req   (irq_req),
  .irq_level (irq_level),
  .ack_evt   (ack_evt),
  .fault_evt (fault_evt)
);

// File: tb/prn_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prn_irq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ack_in = 1'b0;
  logic       fault_in = 1'b1;
  logic       irq_req;
  logic [2:0] irq_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] rd;
    logic       req;
    string      tag;
  } exp_t;

  exp_t q[$];

  always #4 clk = ~clk;

  prn_irq_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ack_in    (ack_in),
    .fault_in  (fault_in),
    .irq_req   (irq_req),
    .irq_level (irq_level)
  );

  // monitor: compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (reg_rdata !== e.rd || irq_req !== e.req || irq_level !== e.rd[2:0]) begin
          errors++;
          $display("FAIL %s: rdata=%h req=%b lvl=%0d expected rdata=%h req=%b lvl=%0d",
                   e.tag, reg_rdata, irq_req, irq_level, e.rd, e.req, e.rd[2:0]);
        end
      end
    end
  end

  task automatic expect_st(input logic [7:0] rd, input logic req, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    e.rd = rd; e.req = req; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic set_ack(input logic v);
    @(negedge clk);
    ack_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_fault(input logic v);
    @(negedge clk);
    fault_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_st(8'h00, 1'b0, "R1 reset value");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_st(8'h00, 1'b0, "R1 after reset release");

    // enable, level 5, rising-edge acknowledge
    wr(8'h0D);
    expect_st(8'h0D, 1'b0, "R2 settings stored");
    set_ack(1'b1);
    expect_st(8'hAD, 1'b1, "R3 R9 R10 rising ack sets flag");
    set_ack(1'b0);
    expect_st(8'hAD, 1'b1, "R11 falling ack ignored in rising mode");
    wr(8'h2D);
    expect_st(8'h0D, 1'b0, "R5 write one clears ack flag");
    wr(8'h8D);
    expect_st(8'h0D, 1'b0, "R5 bit 7 write ignored");

    set_fault(1'b0);
    expect_st(8'hCD, 1'b1, "R4 fault falling edge sets flag");
    set_fault(1'b1);
    expect_st(8'hCD, 1'b1, "R4 fault rising edge no effect");
    wr(8'h0D);
    expect_st(8'hCD, 1'b1, "R5 write zero keeps fault flag");
    wr(8'h4D);
    expect_st(8'h0D, 1'b0, "R5 write one clears fault flag");

    // falling-edge acknowledge, level 6
    wr(8'h1E);
    expect_st(8'h1E, 1'b0, "R2 polarity and level stored");
    set_ack(1'b1);
    expect_st(8'h1E, 1'b0, "R11 rising ack ignored in falling mode");
    set_ack(1'b0);
    expect_st(8'hBE, 1'b1, "R3 falling ack sets flag");
    set_fault(1'b0);
    expect_st(8'hFE, 1'b1, "R9 both flags pending");
    wr(8'h16);
    expect_st(8'hD6, 1'b0, "R7 R10 disable clears ack flag only");
    set_fault(1'b1);
    wr(8'h56);
    expect_st(8'h16, 1'b0, "R5 fault cleared while disabled");

    // disabled: edges ignored
    set_ack(1'b1);
    set_ack(1'b0);
    expect_st(8'h16, 1'b0, "R8 ack edges ignored while disabled");
    set_fault(1'b0);
    expect_st(8'h16, 1'b0, "R8 fault edge ignored while disabled");
    set_fault(1'b1);

    // coincidence of edge and write-one-to-clear
    wr(8'h0D);
    set_ack(1'b1);
    expect_st(8'hAD, 1'b1, "R3 ack flag set before coincidence");
    set_ack(1'b0);
    @(negedge clk);
    ack_in = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 8'h2D;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
    expect_st(8'hAD, 1'b1, "R6 edge beats same-cycle clear");

    // reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    expect_st(8'h00, 1'b0, "R1 reset clears register");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    finish_run();
  end

endmodule